// File: doc/BRIEF.md
# ADC Serial Port with Frame-Sync Mode

This block is the digital serial output port of a 14-bit converter. It sits between a stub conversion engine, which supplies a 14-bit code and two status bits with a one-cycle done strobe, and an external host. The host provides chip select, a serial clock and a receive frame-sync line. All of these are sampled by the block's system clock, so the serial clock has to be several times slower than the system clock.

The port picks its operating mode when chip select falls, from the level of the receive frame-sync line at that moment. In SPI mode it sends a 24-bit frame with the most recent completed result, and data changes on falling serial clock edges. In frame-sync (DSP) mode chip select can stay low. Each rising edge on the receive frame-sync line requests a conversion. Once the converter reports done, the port presents the MSB at the next falling serial clock edge and marks that bit with a transmit frame-sync pulse. It then shifts the remaining result bits and rearms for the next request. Raising chip select aborts any frame.

Top module: `adc_serial_port`

## Requirements
- R1: At the system clock edge where chip select is seen falling, the receive frame-sync level is sampled. A low level selects DSP mode and a high level selects SPI mode. In SPI mode, edges on the receive frame-sync line are ignored, so the conversion request output stays low.
- R2: The data enable output goes low one system clock after chip select is sampled high and goes high one clock after chip select is seen falling. While the enable is low, the data line reads 0.
- R3: An SPI frame is 24 bits: eight zeros, then code bits 13 down to 0, then status bit 1, then status bit 0. The first bit appears one clock after chip select falls, and each later bit appears one clock after each falling serial clock edge.
- R4: An SPI frame carries the result last captured by a done strobe before chip select fell. A done strobe during the frame does not change the bits of that frame, and the new result is used by the next frame.
- R5: In DSP mode, with the port armed, a rising edge on the receive frame-sync line produces a one-clock conversion request pulse one clock later. Rising edges that arrive while a conversion or a frame is in progress produce no request.
- R6: In DSP mode, after the done strobe, the next falling serial clock edge presents code bit 13 and raises transmit frame-sync. The following 15 falling edges present code bits 12 down to 0, then status bit 1 and status bit 0. Falling edges before the done strobe present nothing.
- R7: The transmit frame-sync output stays high for exactly one serial clock period. It falls one system clock after the next falling serial clock edge, or after chip select is sampled high.
- R8: Raising chip select at any point aborts the frame and returns the port to idle. The next falling edge of chip select selects the mode again, and an SPI frame restarts from its first bit.
- R9: After the last DSP bit, the next falling serial clock edge ends the frame. The data line then reads 0 and stays enabled, and the port accepts a new receive frame-sync edge while chip select stays low.
- R10: While reset is held, the data enable, data line, transmit frame-sync and conversion request outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| rfs | input | 1 | Receive frame-sync: mode strap at chip select fall, conversion trigger in DSP mode |
| conv_done | input | 1 | One-clock strobe from the converter; captures conv_code and conv_stat |
| conv_code | input | 14 | Conversion result code |
| conv_stat | input | 2 | Status bits sent after the code |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for the serial data pad (low = high impedance) |
| tfs | output | 1 | Transmit frame-sync, marks the MSB in DSP mode |
| conv_req | output | 1 | One-clock conversion request to the converter |

## Verification
Every result is registered once behind the sampled edge that causes it. A chip select fall, a falling serial clock edge, a chip select rise or a receive frame-sync rise therefore shows up at the outputs one system clock after the rising clock edge that first sees the new input level. The bench changes inputs only just after a falling system clock edge. It reads the outputs at a later falling edge: one clock after the stimulus for enable, request and first-bit checks, and three clocks after each falling serial clock edge for data bits. For the one-period width of transmit frame-sync, it also samples just before the next serial clock fall.

// File: rtl/adc_sp_pkg.sv
// Package: shared types for the ADC serial port.
// Assumes: consumers import it before use.
package adc_sp_pkg;

    // Control states of the port
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SPI       = 3'd1,
        ST_DSP_ARM   = 3'd2,
        ST_DSP_CONV  = 3'd3,
        ST_DSP_RDY   = 3'd4,
        ST_DSP_SHIFT = 3'd5
    } port_st_e;

    // Commands from the controller to the shift datapath
    typedef enum logic [2:0] {
        OP_HOLD     = 3'd0,
        OP_CLEAR    = 3'd1,
        OP_LOAD_SPI = 3'd2,
        OP_LOAD_DSP = 3'd3,
        OP_SHIFT    = 3'd4
    } shift_op_e;

endpackage

// File: rtl/adc_sp_edges.sv
// Module: adc_sp_edges
// Turns N sampled inputs into one-clock edge events. EDGE_SEL chooses per
// bit whether a rising (1) or falling (0) edge is reported.
// Assumes: inputs are already synchronous to clk or slow enough to sample.
module adc_sp_edges #(
    parameter int          N        = 3,
    parameter logic [N-1:0] EDGE_SEL = '0,
    parameter logic [N-1:0] RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] evt
);

    logic [N-1:0] prev_q;

    // Keep the previous sampled level of every input
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= sig;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        if (EDGE_SEL[g]) begin : g_rise
            // Report a rising edge on this input
            always_comb evt[g] = sig[g] & ~prev_q[g];
        end else begin : g_fall
            // Report a falling edge on this input
            always_comb evt[g] = ~sig[g] & prev_q[g];
        end
    end

endmodule

// File: rtl/adc_sp_ctrl.sv
// Module: adc_sp_ctrl
// Mode selection and frame sequencing. Chooses SPI or DSP mode at the chip
// select fall, issues conversion requests, times the transmit frame-sync
// and tells the shift datapath what to do on each clock.
// Assumes: edge events are single-clock pulses from adc_sp_edges.
module adc_sp_ctrl
    import adc_sp_pkg::*;
#(
    parameter int DSP_BITS = 16,
    localparam int CNT_W   = $clog2(DSP_BITS)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n,
    input  logic      cs_fall,
    input  logic      sclk_fall,
    input  logic      rfs,
    input  logic      rfs_rise,
    input  logic      conv_done,
    output shift_op_e op,
    output logic      oe,
    output logic      tfs,
    output logic      conv_req
);

    port_st_e         st_q;
    logic [CNT_W-1:0] cnt_q;

    // Sequence the port state, enable, frame-sync and request outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            oe       <= 1'b0;
            tfs      <= 1'b0;
            conv_req <= 1'b0;
        end else begin
            conv_req <= 1'b0;
            if (cs_n) begin
                st_q <= ST_IDLE;
                oe   <= 1'b0;
                tfs  <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        if (cs_fall) begin
                            oe   <= 1'b1;
                            st_q <= rfs ? ST_SPI : ST_DSP_ARM;
                        end
                    end
                    ST_SPI: begin
                        st_q <= ST_SPI;
                    end
                    ST_DSP_ARM: begin
                        if (rfs_rise) begin
                            conv_req <= 1'b1;
                            st_q     <= ST_DSP_CONV;
                        end
                    end
                    ST_DSP_CONV: begin
                        if (conv_done) st_q <= ST_DSP_RDY;
                    end
                    ST_DSP_RDY: begin
                        if (sclk_fall) begin
                            st_q  <= ST_DSP_SHIFT;
                            tfs   <= 1'b1;
                            cnt_q <= '0;
                        end
                    end
                    ST_DSP_SHIFT: begin
                        if (sclk_fall) begin
                            tfs <= 1'b0;
                            if (cnt_q == CNT_W'(DSP_BITS - 1)) st_q <= ST_DSP_ARM;
                            else                               cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Decode the datapath command for this clock
    always_comb begin
        op = OP_HOLD;
        if (cs_n) begin
            op = OP_CLEAR;
        end else begin
            unique case (st_q)
                ST_IDLE:      if (cs_fall)   op = rfs ? OP_LOAD_SPI : OP_CLEAR;
                ST_SPI:       if (sclk_fall) op = OP_SHIFT;
                ST_DSP_RDY:   if (sclk_fall) op = OP_LOAD_DSP;
                ST_DSP_SHIFT: if (sclk_fall) op = OP_SHIFT;
                default:      op = OP_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/adc_sp_data.sv
// Module: adc_sp_data
// Result capture and output shift register. A done strobe stores the
// converter result. Loads copy the stored result into the frame register
// in SPI or DSP layout, and shifts move it out MSB first, filling with 0.
// Assumes: op comes from adc_sp_ctrl and carries one command per clock.
module adc_sp_data
    import adc_sp_pkg::*;
#(
    parameter int  CODE_W  = 14,
    parameter int  STAT_W  = 2,
    parameter int  LEAD_W  = 8,
    localparam int RES_W   = CODE_W + STAT_W,
    localparam int FRAME_W = LEAD_W + RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  shift_op_e         op,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] conv_code,
    input  logic [STAT_W-1:0] conv_stat,
    output logic              sdo
);

    logic [RES_W-1:0]   result_q;
    logic [FRAME_W-1:0] frame_q;

    // Hold the last completed conversion result
    always_ff @(posedge clk) begin
        if (!rst_n)         result_q <= '0;
        else if (conv_done) result_q <= {conv_code, conv_stat};
    end

    // Load, shift or clear the outgoing frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR:    frame_q <= '0;
                OP_LOAD_SPI: frame_q <= {{LEAD_W{1'b0}}, result_q};
                OP_LOAD_DSP: frame_q <= {result_q, {LEAD_W{1'b0}}};
                OP_SHIFT:    frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                default:     frame_q <= frame_q;
            endcase
        end
    end

    assign sdo = frame_q[FRAME_W-1];

endmodule

// File: rtl/adc_serial_port.sv
// Module: adc_serial_port (top)
// Serial output port of a 14-bit converter with an SPI read mode and a
// DSP frame-sync mode. The mode is chosen at each chip select fall.
// Assumes: sclk, cs_n and rfs change slowly compared with clk, so every
// level lasts at least two clk periods.
module adc_serial_port #(
    parameter int  CODE_W   = 14,
    parameter int  STAT_W   = 2,
    parameter int  LEAD_W   = 8,
    localparam int DSP_BITS = CODE_W + STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              rfs,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] conv_code,
    input  logic [STAT_W-1:0] conv_stat,
    output logic              sdo,
    output logic              sdo_en,
    output logic              tfs,
    output logic              conv_req
);
    import adc_sp_pkg::*;

    logic [2:0] evt;
    shift_op_e  op;

    // Edge events: bit 0 cs_n fall, bit 1 sclk fall, bit 2 rfs rise
    adc_sp_edges #(
        .N        (3),
        .EDGE_SEL (3'b100),
        .RST_VAL  (3'b101)
    ) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({rfs, sclk, cs_n}),
        .evt   (evt)
    );

    adc_sp_ctrl #(
        .DSP_BITS (DSP_BITS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cs_fall   (evt[0]),
        .sclk_fall (evt[1]),
        .rfs       (rfs),
        .rfs_rise  (evt[2]),
        .conv_done (conv_done),
        .op        (op),
        .oe        (sdo_en),
        .tfs       (tfs),
        .conv_req  (conv_req)
    );

    adc_sp_data #(
        .CODE_W (CODE_W),
        .STAT_W (STAT_W),
        .LEAD_W (LEAD_W)
    ) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .conv_done (conv_done),
        .conv_code (conv_code),
        .conv_stat (conv_stat),
        .sdo       (sdo)
    );

endmodule

// File: rtl/adc_serial_port_chk.sv
// Module: adc_serial_port_chk
// Port-level properties of adc_serial_port, bound to every instance.
// Assumes: it sees the top module's ports by name.
module adc_serial_port_chk #(
    parameter int CODE_W = 14,
    parameter int STAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sclk,
    input logic              rfs,
    input logic              conv_done,
    input logic [CODE_W-1:0] conv_code,
    input logic [STAT_W-1:0] conv_stat,
    input logic              sdo,
    input logic              sdo_en,
    input logic              tfs,
    input logic              conv_req
);

    // R2: chip select high releases the line on the next clock
    a_r2_release_line: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_en);

    // R5: the request is a single-clock pulse
    a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R5: a request follows a rising receive frame-sync edge
    a_r5_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> ($past(rfs) && !$past(rfs, 2)));

    // R7: transmit frame-sync holds until a serial clock fall or deselect
    a_r7_tfs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tfs && !cs_n && !($past(sclk) && !sclk)) |=> tfs);

    // R6: frame-sync is only raised while the line is driven
    a_r6_tfs_driven: assert property (@(posedge clk) disable iff (!rst_n)
        tfs |-> sdo_en);

    // R2: a released line carries 0
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en |-> !sdo);

endmodule

bind adc_serial_port adc_serial_port_chk #(
    .CODE_W (CODE_W),
    .STAT_W (STAT_W)
) u_chk (.*);

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n;
    logic        sclk;
    logic        rfs;
    logic        conv_done;
    logic [13:0] conv_code;
    logic [1:0]  conv_stat;
    logic        sdo;
    logic        sdo_en;
    logic        tfs;
    logic        conv_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [13:0] last_code;
    logic [1:0]  last_stat;

    always #5 clk = ~clk;

    adc_serial_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .rfs       (rfs),
        .conv_done (conv_done),
        .conv_code (conv_code),
        .conv_stat (conv_stat),
        .sdo       (sdo),
        .sdo_en    (sdo_en),
        .tfs       (tfs),
        .conv_req  (conv_req)
    );

    function automatic logic [23:0] spi_exp(input logic [13:0] c, input logic [1:0] s);
        return {8'h00, c, s};
    endfunction

    function automatic logic [15:0] dsp_exp(input logic [13:0] c, input logic [1:0] s);
        return {c, s};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic convert(input logic [13:0] c, input logic [1:0] s);
        conv_code = c;
        conv_stat = s;
        conv_done = 1'b1;
        cyc(1);
        conv_done = 1'b0;
        last_code = c;
        last_stat = s;
    endtask

    task automatic sclk_fall_only();
        sclk = 1'b1; cyc(3);
        sclk = 1'b0; cyc(3);
    endtask

    // Full SPI read; optional done strobe injected at bit 5 (R4)
    task automatic spi_read(input logic [23:0] exp, input bit inject,
                            input logic [13:0] nc, input logic [1:0] ns);
        rfs = 1'b1; cs_n = 1'b1; cyc(1);
        cs_n = 1'b0; cyc(1);
        chk("R2 enable after select", 32'(sdo_en), 32'd1);
        for (int i = 0; i < 24; i++) begin
            chk("R3 spi bit", 32'(sdo), 32'(exp[23-i]));
            sclk = 1'b1; cyc(3);
            sclk = 1'b0;
            if (inject && i == 5) begin
                conv_code = nc; conv_stat = ns; conv_done = 1'b1;
                cyc(1);
                conv_done = 1'b0;
                last_code = nc; last_stat = ns;
                cyc(2);
            end else begin
                cyc(3);
            end
        end
        cs_n = 1'b1; cyc(1);
        chk("R2 release after deselect", 32'(sdo_en), 32'd0);
        chk("R2 line zero when released", 32'(sdo), 32'd0);
    endtask

    task automatic enter_dsp();
        cs_n = 1'b1; rfs = 1'b0; cyc(1);
        cs_n = 1'b0; cyc(1);
        chk("R1 dsp select enables", 32'(sdo_en), 32'd1);
        chk("R1 dsp armed line low", 32'(sdo), 32'd0);
        chk("R1 dsp armed no tfs", 32'(tfs), 32'd0);
    endtask

    task automatic dsp_run(input logic [13:0] c, input logic [1:0] s);
        logic [15:0] e;
        e = dsp_exp(c, s);
        rfs = 1'b1; cyc(1);
        chk("R5 request pulse", 32'(conv_req), 32'd1);
        rfs = 1'b0; cyc(1);
        chk("R5 request one clock", 32'(conv_req), 32'd0);
        rfs = 1'b1; cyc(1);
        chk("R5 busy edge ignored", 32'(conv_req), 32'd0);
        rfs = 1'b0; cyc(1);
        sclk_fall_only();
        chk("R6 no frame before done", 32'(tfs), 32'd0);
        convert(c, s);
        for (int i = 0; i < 16; i++) begin
            sclk = 1'b1; cyc(3);
            chk("R7 tfs before next fall", 32'(tfs), 32'(i == 1));
            sclk = 1'b0; cyc(1);
            chk("R6 tfs after fall", 32'(tfs), 32'(i == 0));
            chk("R6 dsp bit", 32'(sdo), 32'(e[15-i]));
            cyc(2);
        end
        sclk_fall_only();
        chk("R9 line low after frame", 32'(sdo), 32'd0);
        chk("R9 still enabled", 32'(sdo_en), 32'd1);
        chk("R9 tfs low after frame", 32'(tfs), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; rfs = 1'b1;
        conv_done = 1'b0; conv_code = '0; conv_stat = '0;
        last_code = '0; last_stat = '0;
        cyc(4);
        chk("R10 reset sdo_en", 32'(sdo_en), 32'd0);
        chk("R10 reset sdo", 32'(sdo), 32'd0);
        chk("R10 reset tfs", 32'(tfs), 32'd0);
        chk("R10 reset conv_req", 32'(conv_req), 32'd0);
        rst_n = 1'b1; cyc(2);

        // R4: nothing converted yet -> zero result
        spi_read(spi_exp(14'h0, 2'b00), 1'b0, '0, '0);
        // R4: result captured before select, mid-frame strobe does not alter it
        convert(14'h2A5C, 2'b10);
        spi_read(spi_exp(14'h2A5C, 2'b10), 1'b1, 14'h1234, 2'b11);
        spi_read(spi_exp(14'h1234, 2'b11), 1'b0, '0, '0);
        spi_read(spi_exp(14'h1234, 2'b11), 1'b0, '0, '0);
        convert(14'h3FFF, 2'b01);
        spi_read(spi_exp(14'h3FFF, 2'b01), 1'b0, '0, '0);

        // R1: receive frame-sync edges ignored in SPI mode
        rfs = 1'b1; cs_n = 1'b0; cyc(1);
        rfs = 1'b0; cyc(1);
        rfs = 1'b1; cyc(1);
        chk("R1 no request in spi mode", 32'(conv_req), 32'd0);
        cyc(1);
        chk("R1 no request in spi mode later", 32'(conv_req), 32'd0);
        cs_n = 1'b1; cyc(1);

        // R8: abort SPI mid-frame, restart from first bit
        rfs = 1'b1; cs_n = 1'b0; cyc(1);
        for (int i = 0; i < 12; i++) sclk_fall_only();
        cs_n = 1'b1; cyc(1);
        chk("R8 abort releases line", 32'(sdo_en), 32'd0);
        spi_read(spi_exp(14'h3FFF, 2'b01), 1'b0, '0, '0);

        // DSP mode directed patterns
        enter_dsp();
        dsp_run(14'h2001, 2'b10);
        dsp_run(14'h1555, 2'b01);
        dsp_run(14'h0000, 2'b11);
        cs_n = 1'b1; cyc(1);

        // R8: abort DSP mid-frame then reselect SPI
        enter_dsp();
        rfs = 1'b1; cyc(1); rfs = 1'b0; cyc(1);
        convert(14'h0F0F, 2'b10);
        sclk_fall_only();
        chk("R8 dsp frame started", 32'(tfs), 32'd1);
        sclk_fall_only();
        sclk_fall_only();
        cs_n = 1'b1; cyc(1);
        chk("R8 dsp abort releases", 32'(sdo_en), 32'd0);
        chk("R8 dsp abort clears tfs", 32'(tfs), 32'd0);
        spi_read(spi_exp(14'h0F0F, 2'b10), 1'b0, '0, '0);

        // Random mix of modes
        for (int t = 0; t < 12; t++) begin
            logic [13:0] rc;
            logic [1:0]  rs;
            rc = 14'($urandom);
            rs = 2'($urandom);
            if ($urandom % 2 == 0) begin
                convert(rc, rs);
                spi_read(spi_exp(rc, rs), 1'b0, '0, '0);
            end else begin
                enter_dsp();
                dsp_run(rc, rs);
                cs_n = 1'b1; cyc(1);
                chk("R2 release after dsp", 32'(sdo_en), 32'd0);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule